// File: doc/BRIEF.md
# PHY Event Counters and Interrupt Controller

This block sits beside a 10/100 Ethernet PHY receive path and keeps error statistics and interrupt state for software. Two 8-bit counters record false-carrier events and qualified receive-symbol errors. Each counter saturates instead of wrapping and clears when software reads it. A pair of sticky flags remembers whether either kind of event has happened since its counter was last read.

Six event sources feed one pending-interrupt bit, and each source has its own mask. Four of the sources are PHY event pulses: link change, jabber, remote fault and auto-negotiation done. The other two are the half-full crossings of the counters. A test mode raises the pending bit at the end of every management read, so software can exercise its interrupt path without any line activity.

Software reaches the block through a plain 16-bit register port with a 3-bit address, a read strobe and a write strobe. The port has no flow control. A read strobe is accepted in the cycle it is high. The read data is registered and appears in the following cycle. A write strobe takes effect at the clock edge.

Top module: `phy_evt_irq`

## Requirements
- R1: Each event counter is CNT_W bits wide (default 8). It adds one per qualifying event and holds at its all-ones value (FFh) instead of wrapping.
- R2: A read of a counter register returns the count zero-extended to 16 bits and clears the counter to 0. Writes to a counter register have no effect.
- R3: The receive-error counter adds one when a symbol error occurs while carrier is high, at most once per carrier event. It does not count an error if collision is high in the same cycle or was high earlier in the same carrier event. Errors while carrier is low are not counted.
- R4: If an event arrives in the same cycle as a read of its counter, the read returns the old value and the counter becomes 1. The event's sticky flag stays set.
- R5: The status register at address 1 holds six mask bits. A mask bit of 0 enables its source. The bit positions are: 14 link change, 13 jabber, 12 remote fault, 11 auto-negotiation done, 10 false-carrier half-full, 9 receive-error half-full.
- R6: The pending bit is bit 15 of the status register, and irq_o follows it. It sets only when an unmasked event occurs while the enable bit (bit 1 of the control register at address 0) is 1. A read of the status register clears it, unless a new set occurs in that same cycle. Writes to the pending bit are ignored.
- R7: While the test bit (bit 0 of the control register) is 1, every management read sets the pending bit, whatever the value of the enable bit.
- R8: The flags register at address 4 is read-only. Bit 0 is the false-carrier flag and bit 1 is the receive-error flag. Each flag sets on its event. Each flag clears only on a read of its own counter register.
- R9: A half-full event is a single pulse. It fires when a counter steps from 7Fh to 80h and cannot fire again until that counter has been cleared.
- R10: Every register resets to 0000h and irq_o resets low. Reserved bits read as 0 and ignore writes. Addresses 5 to 7 read as 0000h. Address 2 is the false-carrier counter and address 3 is the receive-error counter.
- R11: Read data appears on mgmt_rdata_o in the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| fc_evt_i | input | 1 | False-carrier event pulse |
| sym_err_i | input | 1 | Invalid receive symbol pulse |
| crs_i | input | 1 | Carrier-active level |
| col_i | input | 1 | Collision level |
| link_chg_i | input | 1 | Link status change pulse |
| jabber_i | input | 1 | Jabber event pulse |
| rfault_i | input | 1 | Remote fault event pulse |
| an_done_i | input | 1 | Auto-negotiation complete pulse |
| mgmt_addr_i | input | 3 | Register address |
| mgmt_rd_i | input | 1 | Read strobe |
| mgmt_wr_i | input | 1 | Write strobe |
| mgmt_wdata_i | input | 16 | Write data |
| mgmt_rdata_o | output | 16 | Registered read data |
| irq_o | output | 1 | Pending interrupt line |

## Verification
The bench builds the block with its default CNT_W of 8, so every counter value can be reached in a few hundred event pulses. It sweeps the false-carrier count through 0, 1, 5, 127, 128, 200, 255, 256 and 300 events, and its expected values come from min(n, 255). Driving 128 events reaches the half-full crossing, and the bench follows the counter on to saturation and past it. Each pulse source is unmasked in turn while the others stay masked.

// File: rtl/phy_evt_pkg.sv
package phy_evt_pkg;
  localparam int REG_W    = 16;
  localparam int ADDR_W   = 3;
  localparam int NUM_SRC  = 6;
  localparam int MASK_LSB = 9;
  localparam int PEND_BIT = 15;
  localparam int EN_BIT   = 1;
  localparam int TEST_BIT = 0;
  localparam int FLG_FC   = 0;
  localparam int FLG_RX   = 1;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_FCCNT = 3'd2;
  localparam logic [ADDR_W-1:0] A_RXCNT = 3'd3;
  localparam logic [ADDR_W-1:0] A_FLAGS = 3'd4;

  // source index i maps to mask bit MASK_LSB + i
  localparam int SRC_RXHALF = 0;
  localparam int SRC_FCHALF = 1;
  localparam int SRC_ANDONE = 2;
  localparam int SRC_RFAULT = 3;
  localparam int SRC_JABBER = 4;
  localparam int SRC_LINK   = 5;
endpackage

// File: rtl/sat_clr_counter.sv
module sat_clr_counter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o,
  output logic         half_o
);
  localparam logic [W-1:0] MAXV    = {W{1'b1}};
  localparam logic [W-1:0] HALF_M1 = {1'b0, {(W-1){1'b1}}};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= inc_i ? W'(1) : '0;
    end else if (inc_i && cnt_q != MAXV) begin
      cnt_q <= cnt_q + W'(1);
    end
  end

  assign cnt_o  = cnt_q;
  assign half_o = inc_i && !clr_i && (cnt_q == HALF_M1);
endmodule

// File: rtl/rxerr_qual.sv
module rxerr_qual (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic crs_i,
  input  logic col_i,
  input  logic sym_err_i,
  output logic qual_o
);
  logic counted_q, col_seen_q;

  assign qual_o = crs_i && sym_err_i && !col_i && !col_seen_q && !counted_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni || !crs_i) begin
      counted_q  <= 1'b0;
      col_seen_q <= 1'b0;
    end else begin
      if (col_i)  col_seen_q <= 1'b1;
      if (qual_o) counted_q  <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int NSRC = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] mask_i,
  input  logic            en_i,
  input  logic            test_i,
  input  logic            rd_done_i,
  input  logic            clr_i,
  output logic            pend_o
);
  logic pend_q, set;

  assign set = (en_i && |(src_i & ~mask_i)) || (test_i && rd_done_i);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= (pend_q && !clr_i) || set;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/phy_evt_irq.sv
module phy_evt_irq
  import phy_evt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fc_evt_i,
  input  logic              sym_err_i,
  input  logic              crs_i,
  input  logic              col_i,
  input  logic              link_chg_i,
  input  logic              jabber_i,
  input  logic              rfault_i,
  input  logic              an_done_i,
  input  logic [2:0]        mgmt_addr_i,
  input  logic              mgmt_rd_i,
  input  logic              mgmt_wr_i,
  input  logic [15:0]       mgmt_wdata_i,
  output logic [15:0]       mgmt_rdata_o,
  output logic              irq_o
);
  localparam int CW = (CNT_W < REG_W) ? CNT_W : REG_W;

  logic [CNT_W-1:0]   fc_cnt, rx_cnt;
  logic               fc_half, rx_half, rx_qual;
  logic               rd_fc, rd_rx, rd_stat;
  logic [1:0]         ctrl_q;
  logic [NUM_SRC-1:0] mask_q, src_vec;
  logic               fc_flag_q, rx_flag_q, pend;
  logic [REG_W-1:0]   rd_mux, rdata_q;
  logic               unused_wbits;

  assign unused_wbits = ^{mgmt_wdata_i[15], mgmt_wdata_i[8:2]};

  assign rd_fc   = mgmt_rd_i && (mgmt_addr_i == A_FCCNT);
  assign rd_rx   = mgmt_rd_i && (mgmt_addr_i == A_RXCNT);
  assign rd_stat = mgmt_rd_i && (mgmt_addr_i == A_STAT);

  rxerr_qual u_qual (
    .clk_i, .rst_ni, .crs_i, .col_i, .sym_err_i, .qual_o(rx_qual)
  );

  sat_clr_counter #(.W(CNT_W)) u_fc_cnt (
    .clk_i, .rst_ni, .inc_i(fc_evt_i), .clr_i(rd_fc),
    .cnt_o(fc_cnt), .half_o(fc_half)
  );

  sat_clr_counter #(.W(CNT_W)) u_rx_cnt (
    .clk_i, .rst_ni, .inc_i(rx_qual), .clr_i(rd_rx),
    .cnt_o(rx_cnt), .half_o(rx_half)
  );

  always_comb begin
    src_vec             = '0;
    src_vec[SRC_RXHALF] = rx_half;
    src_vec[SRC_FCHALF] = fc_half;
    src_vec[SRC_ANDONE] = an_done_i;
    src_vec[SRC_RFAULT] = rfault_i;
    src_vec[SRC_JABBER] = jabber_i;
    src_vec[SRC_LINK]   = link_chg_i;
  end

  irq_ctrl #(.NSRC(NUM_SRC)) u_irq (
    .clk_i, .rst_ni, .src_i(src_vec), .mask_i(mask_q),
    .en_i(ctrl_q[EN_BIT]), .test_i(ctrl_q[TEST_BIT]),
    .rd_done_i(mgmt_rd_i), .clr_i(rd_stat), .pend_o(pend)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mask_q <= '0;
    end else if (mgmt_wr_i) begin
      if (mgmt_addr_i == A_CTRL) ctrl_q <= mgmt_wdata_i[1:0];
      if (mgmt_addr_i == A_STAT) mask_q <= mgmt_wdata_i[MASK_LSB +: NUM_SRC];
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      fc_flag_q <= 1'b0;
      rx_flag_q <= 1'b0;
    end else begin
      if (fc_evt_i)   fc_flag_q <= 1'b1;
      else if (rd_fc) fc_flag_q <= 1'b0;
      if (rx_qual)    rx_flag_q <= 1'b1;
      else if (rd_rx) rx_flag_q <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (mgmt_addr_i)
      A_CTRL:  rd_mux[1:0] = ctrl_q;
      A_STAT: begin
        rd_mux[PEND_BIT]               = pend;
        rd_mux[MASK_LSB +: NUM_SRC]    = mask_q;
      end
      A_FCCNT: rd_mux[CW-1:0] = fc_cnt[CW-1:0];
      A_RXCNT: rd_mux[CW-1:0] = rx_cnt[CW-1:0];
      A_FLAGS: begin
        rd_mux[FLG_FC] = fc_flag_q;
        rd_mux[FLG_RX] = rx_flag_q;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)        rdata_q <= '0;
    else if (mgmt_rd_i) rdata_q <= rd_mux;
  end

  assign mgmt_rdata_o = rdata_q;
  assign irq_o        = pend;
endmodule

// File: rtl/phy_evt_irq_chk.sv
module phy_evt_irq_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             crs_i,
  input logic             col_i,
  input logic [2:0]       mgmt_addr_i,
  input logic             mgmt_rd_i,
  input logic             mgmt_wr_i,
  input logic [15:0]      mgmt_rdata_o,
  input logic             irq_o,
  input logic [CNT_W-1:0] fc_cnt,
  input logic [CNT_W-1:0] rx_cnt,
  input logic [1:0]       ctrl_q,
  input logic [5:0]       mask_q,
  input logic [5:0]       src_vec
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  logic rd_fc, rd_rx;
  assign rd_fc = mgmt_rd_i && mgmt_addr_i == 3'd2;
  assign rd_rx = mgmt_rd_i && mgmt_addr_i == 3'd3;

  AST_CNT_HOLDS_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fc_cnt == MAXV && !rd_fc) |=> fc_cnt == MAXV); // R1
  AST_CNT_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_rx |=> (rx_cnt == $past(rx_cnt) || rx_cnt == $past(rx_cnt) + 1'b1)); // R1
  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_fc |=> fc_cnt <= 1); // R2
  AST_CNT_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mgmt_rd_i && (mgmt_addr_i == 3'd2 || mgmt_addr_i == 3'd3)) |=> mgmt_rdata_o[15:8] == 8'h00); // R2
  AST_NO_RX_OFF_CARRIER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!crs_i || col_i) |=> rx_cnt <= $past(rx_cnt)); // R3
  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past((ctrl_q[1] && |(src_vec & ~mask_q)) || (ctrl_q[0] && mgmt_rd_i))); // R6
  AST_TEST_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q[0] && mgmt_rd_i) |=> irq_o); // R7
  AST_RDATA_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mgmt_rd_i |=> $stable(mgmt_rdata_o)); // R11
  AST_WR_NO_READ_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mgmt_wr_i && !mgmt_rd_i) |=> $stable(mgmt_rdata_o)); // R2
endmodule

bind phy_evt_irq phy_evt_irq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .crs_i(crs_i), .col_i(col_i),
  .mgmt_addr_i(mgmt_addr_i), .mgmt_rd_i(mgmt_rd_i), .mgmt_wr_i(mgmt_wr_i),
  .mgmt_rdata_o(mgmt_rdata_o), .irq_o(irq_o), .fc_cnt(fc_cnt), .rx_cnt(rx_cnt),
  .ctrl_q(ctrl_q), .mask_q(mask_q), .src_vec(src_vec)
);

// File: tb/phy_evt_irq_bench.sv
module phy_evt_irq_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fc_evt = 0, sym_err = 0, crs = 0, col = 0;
  logic [3:0] ev = '0;   // [3] link, [2] jabber, [1] rfault, [0] an_done
  logic [2:0] mgmt_addr = '0;
  logic mgmt_rd = 0, mgmt_wr = 0;
  logic [15:0] mgmt_wdata = '0;
  logic [15:0] mgmt_rdata;
  logic irq;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_evt_irq u_phy_evt_irq (
    .clk_i(clk), .rst_ni(rst_n), .fc_evt_i(fc_evt), .sym_err_i(sym_err),
    .crs_i(crs), .col_i(col), .link_chg_i(ev[3]), .jabber_i(ev[2]),
    .rfault_i(ev[1]), .an_done_i(ev[0]), .mgmt_addr_i(mgmt_addr),
    .mgmt_rd_i(mgmt_rd), .mgmt_wr_i(mgmt_wr), .mgmt_wdata_i(mgmt_wdata),
    .mgmt_rdata_o(mgmt_rdata), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    mgmt_addr = a; mgmt_rd = 1'b1;
    @(negedge clk);
    mgmt_rd = 1'b0;
    d = mgmt_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    mgmt_addr = a; mgmt_wdata = d; mgmt_wr = 1'b1;
    @(negedge clk);
    mgmt_wr = 1'b0;
  endtask

  task automatic fc_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      fc_evt = 1'b1; @(negedge clk); fc_evt = 1'b0;
    end
  endtask

  task automatic rx_bursts(input int n);
    for (int i = 0; i < n; i++) begin
      crs = 1'b1; sym_err = 1'b1; @(negedge clk);
      crs = 1'b0; sym_err = 1'b0; @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int sweep [9] = '{0, 1, 5, 127, 128, 200, 255, 256, 300};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    check("R10 irq reset", {15'd0, irq}, 16'h0);
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], d); check("R10 reset read", d, 16'h0000);
    end

    // R1 R2 sweep of false-carrier counts
    foreach (sweep[k]) begin
      fc_pulses(sweep[k]);
      rd(3'd2, d); check("R1 saturating count", d, 16'(sweep[k] > 255 ? 255 : sweep[k]));
      rd(3'd2, d); check("R2 cleared on read", d, 16'h0000);
    end

    // R2 writes to counter ignored
    fc_pulses(3);
    wr(3'd2, 16'hFFFF);
    wr(3'd3, 16'h00AA);
    rd(3'd2, d); check("R2 counter write ignored", d, 16'd3);
    rd(3'd3, d); check("R2 rx counter write ignored", d, 16'd0);

    // R8 sticky flags
    fc_pulses(1);
    rd(3'd4, d); check("R8 fc flag set", d, 16'h0001);
    rd(3'd4, d); check("R8 flag read keeps", d, 16'h0001);
    rd(3'd1, d);
    rd(3'd3, d);
    rd(3'd4, d); check("R8 other reads keep", d, 16'h0001);
    rd(3'd2, d);
    rd(3'd4, d); check("R8 own read clears", d, 16'h0000);

    // R3 receive error qualification
    crs = 1'b1; @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      sym_err = 1'b1; @(negedge clk); sym_err = 1'b0; @(negedge clk);
    end
    crs = 1'b0; @(negedge clk);
    rx_bursts(1);
    crs = 1'b1; col = 1'b1; @(negedge clk); col = 1'b0; @(negedge clk);
    sym_err = 1'b1; @(negedge clk); sym_err = 1'b0; crs = 1'b0; @(negedge clk);
    sym_err = 1'b1; @(negedge clk); sym_err = 1'b0; @(negedge clk);
    crs = 1'b1; col = 1'b1; sym_err = 1'b1; @(negedge clk);
    col = 1'b0; sym_err = 1'b0; crs = 1'b0; @(negedge clk);
    rd(3'd4, d); check("R8 rx flag set", d, 16'h0002);
    rd(3'd3, d); check("R3 qualified rx count", d, 16'd2);
    rd(3'd4, d); check("R8 rx flag cleared", d, 16'h0000);

    // R4 event coincides with clearing read
    fc_pulses(5);
    fc_evt = 1'b1; rd(3'd2, d); fc_evt = 1'b0;
    check("R4 old value returned", d, 16'd5);
    rd(3'd4, d); check("R4 flag stays", d, 16'h0001);
    rd(3'd2, d); check("R4 restart at one", d, 16'd1);

    // R10 reserved bits and write filtering
    wr(3'd1, 16'hFFFF);
    rd(3'd1, d); check("R10 status writable bits", d, 16'h7E00);
    wr(3'd5, 16'hFFFF);
    rd(3'd5, d); check("R10 unused address", d, 16'h0000);

    // R5 R6 per-source masks, enable off first
    wr(3'd1, 16'h0000);
    ev = 4'hF; @(negedge clk); ev = '0;
    check("R6 no irq when disabled", {15'd0, irq}, 16'h0);
    wr(3'd0, 16'h0002);
    for (int k = 0; k < 4; k++) begin
      wr(3'd1, 16'h7E00 & ~(16'h0800 << k));
      ev = 4'hF & ~(4'h1 << k); @(negedge clk); ev = '0;
      check("R5 masked sources silent", {15'd0, irq}, 16'h0);
      ev = 4'h1 << k; @(negedge clk); ev = '0;
      check("R5 unmasked source raises", {15'd0, irq}, 16'h1);
      rd(3'd1, d); check("R6 pending bit read", d, 16'h8000 | (16'h7E00 & ~(16'h0800 << k)));
      check("R6 status read clears", {15'd0, irq}, 16'h0);
    end

    // R9 false-carrier half-full
    rd(3'd2, d);
    wr(3'd1, 16'h7A00);
    fc_pulses(127);
    check("R9 below half silent", {15'd0, irq}, 16'h0);
    fc_pulses(1);
    check("R9 fc half-full raises", {15'd0, irq}, 16'h1);
    rd(3'd1, d);
    fc_pulses(200);
    check("R9 no second half pulse", {15'd0, irq}, 16'h0);
    rd(3'd2, d); check("R1 saturated before clear", d, 16'd255);
    fc_pulses(128);
    check("R9 fires again after clear", {15'd0, irq}, 16'h1);
    rd(3'd1, d); rd(3'd2, d);

    // R9 receive-error half-full
    wr(3'd1, 16'h7C00);
    rx_bursts(127);
    check("R9 rx below half silent", {15'd0, irq}, 16'h0);
    rx_bursts(1);
    check("R9 rx half-full raises", {15'd0, irq}, 16'h1);
    rd(3'd1, d);
    rd(3'd3, d); check("R3 one per carrier event", d, 16'd128);

    // R7 test interrupt
    wr(3'd0, 16'hFFFF);
    check("R7 write alone no irq", {15'd0, irq}, 16'h0);
    rd(3'd0, d); check("R10 ctrl writable bits", d, 16'h0003);
    check("R7 read raises irq", {15'd0, irq}, 16'h1);
    wr(3'd0, 16'h0001);
    rd(3'd1, d); check("R7 status read still sets", {15'd0, irq}, 16'h1);
    wr(3'd0, 16'h0000);
    rd(3'd1, d); check("R6 pending seen", d, 16'hFC00);
    check("R6 cleared with test off", {15'd0, irq}, 16'h0);

    // R11 read data holds
    rd(3'd0, d);
    repeat (4) @(negedge clk);
    check("R11 rdata held", mgmt_rdata, 16'h0000);
    wr(3'd1, 16'h0200);
    rd(3'd1, d);
    repeat (3) @(negedge clk);
    check("R11 rdata held after read", mgmt_rdata, 16'h0200);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule